// File: doc/BRIEF.md
# Two-Plane Microcode Sequencer

This block steps a processor that keeps no flag register. Each microinstruction occupies two clock cycles. In the first cycle the sequencer presents its program counter as the microcode fetch address. In the second cycle the fetched microword is executed. At the end of the second cycle the sequencer advances its counter and sets the plane bit of the next address from a condition that it evaluates in that same cycle. The plane bit is bit 14 of the address. A branch is therefore a choice between two sibling words, one in each plane, and no intermediate flag register is involved.

The condition comes from the microword. In FUNC words, where bit 15 is 1, the condition is a 3-bit code. In MOVE words, where bit 15 is 0, the condition is a single bit that is widened to a code. The code chooses among keeping the current plane, a zero test on the data bus, a zero test on the function output, the adder carry-out, and one of two data-bus bits. Straight-line code keeps its plane, so short sequences can sit in either plane.

Top module: `plane_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `fetch_addr` = 0, `exec_phase` = 0 and `plane` = 0.
- R2: After reset the phase alternates on every clock. `exec_phase` is 0 in the fetch cycle and 1 in the execute cycle, starting with fetch.
- R3: `fetch_addr` does not change at the edge that ends a fetch cycle. It changes only at the edge that ends an execute cycle.
- R4: At the end of each execute cycle, address bits [13:0] increase by one modulo 2^14. Bits above bit 14 keep their value.
- R5: The format is taken from microword bit 15. In FUNC words (bit 15 = 1) the condition code is bits [7:5]. In MOVE words (bit 15 = 0) the code is bit 7 copied into all three positions, giving 000 or 111.
- R6: Codes 000 and 011 keep the current plane.
- R7: Codes 100 and 111 set the next plane to 1 exactly when `data_bus` is all zeros.
- R8: Code 001 sets the next plane to 1 exactly when `func_out` is all zeros.
- R9: Code 010 sets the next plane to `carry_out`.
- R10: Code 101 sets the next plane to `data_bus[0]`. Code 110 sets it to `data_bus[15]`.
- R11: `uword`, `data_bus`, `func_out` and `carry_out` are ignored during the fetch cycle. Only their values in the execute cycle affect the next address.
- R12: `plane` always equals bit 14 of `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uword | input | 16 | Fetched microword, valid in the execute cycle |
| data_bus | input | 16 | Data bus value in the execute cycle |
| func_out | input | 16 | Function unit output in the execute cycle |
| carry_out | input | 1 | Adder carry-out in the execute cycle |
| exec_phase | output | 1 | 1 in the execute cycle, 0 in the fetch cycle |
| fetch_addr | output | 16 | Microcode program counter |
| plane | output | 1 | Current code plane (address bit 14) |

## Verification
The bench sweeps every condition code in both word formats. It pairs each code with data and function patterns that separate the zero tests from the single-bit tests. A design that read bits [6:5] of a MOVE word would branch on junk, and a design with a swapped code assignment would pick the wrong source. Inverted values are driven during every fetch cycle, so a design that sampled its inputs in the wrong phase would follow the wrong plane. A long run carries the 14-bit offset through its wrap. A design that let the carry ripple into the plane bit or into bit 15 would then leave the expected address sequence. A reset issued in mid-run checks that the counter, phase and plane all return to zero.

// File: rtl/plane_seq_pkg.sv
package plane_seq_pkg;
   localparam int UW_W    = 16;
   localparam int FMT_BIT = 15;
   localparam int CND_HI  = 7;
   localparam int CND_LO  = 5;

   typedef enum logic [2:0] {
      CND_KEEP_A = 3'b000,
      CND_FZERO  = 3'b001,
      CND_CARRY  = 3'b010,
      CND_KEEP_B = 3'b011,
      CND_DZERO_A= 3'b100,
      CND_DLSB   = 3'b101,
      CND_DMSB   = 3'b110,
      CND_DZERO_B= 3'b111
   } cnd_e;

   typedef enum logic {
      PH_FETCH = 1'b0,
      PH_EXEC  = 1'b1
   } phase_e;
endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
   import plane_seq_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          fmt_func,
   input  logic [2:0]    cnd_field,
   input  logic [DW-1:0] dbus,
   input  logic [DW-1:0] fout,
   input  logic          cy,
   input  logic          cur_plane,
   output logic          nxt_plane
);
   localparam int MSB = DW - 1;

   cnd_e code;
   logic d_zero, f_zero;

   // MOVE words carry one condition bit, widened to 000 / 111
   generate
      if (DW >= 2) begin : g_zero
         assign d_zero = (dbus == '0);
         assign f_zero = (fout == '0);
      end else begin : g_bad
         $error("seq_cond_eval: DW must be at least 2");
      end
   endgenerate

   always_comb begin
      code = fmt_func ? cnd_e'(cnd_field) : cnd_e'({3{cnd_field[2]}});
      unique case (code)
         CND_KEEP_A, CND_KEEP_B:   nxt_plane = cur_plane;
         CND_DZERO_A, CND_DZERO_B: nxt_plane = d_zero;
         CND_FZERO:                nxt_plane = f_zero;
         CND_CARRY:                nxt_plane = cy;
         CND_DLSB:                 nxt_plane = dbus[0];
         CND_DMSB:                 nxt_plane = dbus[MSB];
         default:                  nxt_plane = cur_plane;
      endcase
   end
endmodule

// File: rtl/seq_pc_reg.sv
module seq_pc_reg
   import plane_seq_pkg::*;
#(
   parameter int AW = 16,
   parameter int PB = 14
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          nxt_plane,
   output logic [AW-1:0] pc,
   output logic          in_exec
);
   localparam logic [PB-1:0] OFS_ONE = PB'(1);

   phase_e          ph_q;
   logic [AW-1:0]   pc_q;
   logic [AW-1:0]   pc_nxt;

   always_comb begin
      pc_nxt          = pc_q;
      pc_nxt[PB-1:0]  = pc_q[PB-1:0] + OFS_ONE;
      pc_nxt[PB]      = nxt_plane;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= PH_FETCH;
         pc_q <= '0;
      end else if (ph_q == PH_FETCH) begin
         ph_q <= PH_EXEC;
      end else begin
         ph_q <= PH_FETCH;
         pc_q <= pc_nxt;
      end
   end

   assign pc      = pc_q;
   assign in_exec = (ph_q == PH_EXEC);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (pc_q == '0 && ph_q == PH_FETCH));

   assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ph_q != $past(ph_q)));

   assert_hold_in_fetch_R3: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_FETCH) |=> $stable(pc_q));

   assert_offset_step_R4: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_EXEC) |=> (pc_q[PB-1:0] == $past(pc_q[PB-1:0]) + OFS_ONE));

   generate
      if (PB < AW - 1) begin : g_upper
         assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> $stable(pc_q[AW-1:PB+1]));
      end
   endgenerate
endmodule

// File: rtl/plane_seq.sv
module plane_seq
   import plane_seq_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 16,
   parameter int PB = 14
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [15:0]   uword,
   input  logic [DW-1:0] data_bus,
   input  logic [DW-1:0] func_out,
   input  logic          carry_out,
   output logic          exec_phase,
   output logic [AW-1:0] fetch_addr,
   output logic          plane
);
   generate
      if (AW < 2 || PB < 1 || PB >= AW) begin : g_bad_cfg
         $error("plane_seq: plane bit must lie inside the address above bit 0");
      end
      if (UW_W != 16) begin : g_bad_uw
         $error("plane_seq: microword width must be 16");
      end
   endgenerate

   logic nxt_plane;
   logic unused_uw;
   assign unused_uw = ^{uword[14:8], uword[4:0]};

   seq_cond_eval #(.DW(DW)) u_cond (
      .fmt_func  (uword[FMT_BIT]),
      .cnd_field (uword[CND_HI:CND_LO]),
      .dbus      (data_bus),
      .fout      (func_out),
      .cy        (carry_out),
      .cur_plane (fetch_addr[PB]),
      .nxt_plane (nxt_plane)
   );

   seq_pc_reg #(.AW(AW), .PB(PB)) u_pc (
      .clk       (clk),
      .rst       (rst),
      .nxt_plane (nxt_plane),
      .pc        (fetch_addr),
      .in_exec   (exec_phase)
   );

   assign plane = fetch_addr[PB];

   assert_keep_plane_R6: assert property (@(posedge clk) disable iff (rst)
      (exec_phase && (uword[15] ? (uword[7:5] == 3'b000 || uword[7:5] == 3'b011)
                                : !uword[7])) |=> $stable(plane));

   assert_data_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (exec_phase && (uword[15] ? (uword[7:5] == 3'b100 || uword[7:5] == 3'b111)
                                : uword[7])) |=> (plane == ($past(data_bus) == '0)));

   assert_carry_sel_R9: assert property (@(posedge clk) disable iff (rst)
      (exec_phase && uword[15] && uword[7:5] == 3'b010) |=> (plane == $past(carry_out)));

   assert_fetch_ignored_R11: assert property (@(posedge clk) disable iff (rst)
      !exec_phase |=> $stable(plane));
endmodule

// File: tb/tb_plane_seq.sv
module tb_plane_seq;
   localparam int DW = 16;
   localparam int AW = 16;
   localparam int PB = 14;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [15:0]   uword = '0;
   logic [DW-1:0] data_bus = '0;
   logic [DW-1:0] func_out = '0;
   logic          carry_out = 1'b0;
   logic          exec_phase;
   logic [AW-1:0] fetch_addr;
   logic          plane;

   int total = 0;
   int bad = 0;
   logic [AW-1:0] exp_pc = '0;
   logic [31:0]   seed = 32'h1234_5679;

   plane_seq #(.DW(DW), .AW(AW), .PB(PB)) dut (
      .clk(clk), .rst(rst), .uword(uword), .data_bus(data_bus),
      .func_out(func_out), .carry_out(carry_out),
      .exec_phase(exec_phase), .fetch_addr(fetch_addr), .plane(plane)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] code_of(input logic [15:0] w);
      return w[15] ? w[7:5] : {3{w[7]}};
   endfunction

   function automatic logic model_plane(input logic [15:0] w, input logic [DW-1:0] d,
                                        input logic [DW-1:0] f, input logic c,
                                        input logic cur);
      case (code_of(w))
         3'b000, 3'b011: return cur;
         3'b100, 3'b111: return (d == 0);
         3'b001:         return (f == 0);
         3'b010:         return c;
         3'b101:         return d[0];
         default:        return d[DW-1];
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] w);
      case (code_of(w))
         3'b000, 3'b011: return w[15] ? "R6 R11" : "R5 R6 R11";
         3'b100, 3'b111: return w[15] ? "R7 R11" : "R5 R7 R11";
         3'b001:         return "R8 R11";
         3'b010:         return "R9 R11";
         default:        return "R10 R11";
      endcase
   endfunction

   // entered at a negedge inside a fetch cycle
   task automatic step(input logic [15:0] w, input logic [DW-1:0] d,
                       input logic [DW-1:0] f, input logic c);
      logic np;
      chk(exec_phase == 1'b0, "R2 fetch phase", 32'(exec_phase), 0);
      chk(fetch_addr == exp_pc, "R3 address at fetch", 32'(fetch_addr), 32'(exp_pc));
      uword = ~w; data_bus = ~d; func_out = ~f; carry_out = ~c;
      @(posedge clk); @(negedge clk);
      chk(exec_phase == 1'b1, "R2 execute phase", 32'(exec_phase), 1);
      chk(fetch_addr == exp_pc, "R3 address held over fetch edge",
          32'(fetch_addr), 32'(exp_pc));
      uword = w; data_bus = d; func_out = f; carry_out = c;
      @(posedge clk); @(negedge clk);
      np = model_plane(w, d, f, c, exp_pc[PB]);
      exp_pc[PB-1:0] = exp_pc[PB-1:0] + 1'b1;
      exp_pc[PB] = np;
      chk(fetch_addr[PB-1:0] == exp_pc[PB-1:0], "R4 offset step",
          32'(fetch_addr[PB-1:0]), 32'(exp_pc[PB-1:0]));
      chk(fetch_addr[AW-1] == exp_pc[AW-1], "R4 upper bit",
          32'(fetch_addr[AW-1]), 32'(exp_pc[AW-1]));
      chk(plane == np, tag_of(w), 32'(plane), 32'(np));
      chk(plane == fetch_addr[PB], "R12 plane bit", 32'(plane), 32'(fetch_addr[PB]));
   endtask

   task automatic reset_check();
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(fetch_addr == '0, "R1 address", 32'(fetch_addr), 0);
      chk(exec_phase == 1'b0, "R1 phase", 32'(exec_phase), 0);
      chk(plane == 1'b0, "R1 plane", 32'(plane), 0);
      rst = 1'b0;
      exp_pc = '0;
   endtask

   initial begin
      #(200000 * 20);
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(posedge clk); @(negedge clk);
      reset_check();
      // directed sweep: every code, both formats, eight data patterns
      for (int code = 0; code < 8; code++) begin
         for (int fmt = 0; fmt < 2; fmt++) begin
            for (int p = 0; p < 8; p++) begin
               logic [15:0] w;
               logic [DW-1:0] d, f;
               w = {fmt[0], 7'(7'h55 ^ p), code[2:0], 5'(p * 3)};
               d = p[0] ? 16'h0000 : (p[1] ? 16'h8001 : 16'h7FFE);
               f = p[1] ? 16'h0000 : 16'(16'h0100 ^ p);
               step(w, d, f, p[2]);
            end
         end
      end
      reset_check();
      // long pseudo-random run crosses the 14-bit offset wrap
      for (int i = 0; i < 16500; i++) begin
         logic [DW-1:0] d, f;
         seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
         d = (i % 5 == 0) ? 16'h0 : seed[31:16];
         f = (i % 7 == 0) ? 16'h0 : seed[23:8];
         step(seed[15:0], d, f, seed[20]);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule